// File: doc/BRIEF.md
# NAND flash command sequencer

This block runs one NAND flash access from a small set of host-written registers. A control byte says which stages take part and how. A 32-bit address register and a pair of command-byte registers supply the bytes that go out on the flash bus. When the host pulses `start`, the sequencer walks through a fixed order of stages: a leading command byte, an address phase of one to four bytes, a data phase that writes or reads, and a trailing command byte. Any stage may be switched off, and a stage that is off costs no cycles.

The flash side is a simplified strobe bus: command latch, address latch, an active-low write strobe and an active-low read strobe, plus an 8-bit I/O bus with an output-enable. Write bytes come in through a valid/ready byte stream, and read bytes leave through another. A 16-bit sector counter decides how many sectors of `SECTOR_BYTES` bytes the data phase moves. In sector mode the count comes from the host. In command mode it is forced to one. The host sees `busy`, a one-cycle `done` pulse and the live remaining-sector count.

Top module: `nfc_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `nf_cle`, `nf_ale` and `nf_io_oe` are 0, `nf_we_n` and `nf_re_n` are 1, `sect_left` is 0, and the control readback (`host_sel`=0) is 0.
- R2: The host register select codes are 0 for control, 1 for address and 2 for commands; any other code reads 0. The control layout is: bit0 leading command on, bit1 address phase on, bit2 trailing command on, bit3 data direction (1 write, 0 read), bits 5:4 address length, bits 7:6 reserved, bits 23:8 sector count. The reserved bits and bits 31:24 always read 0. The commands register holds the leading command in bits 7:0 and the trailing command in bits 15:8.
- R3: Enabled stages run in the order leading command, address, data, trailing command. The first cycle of each stage follows the previous stage with no gap, and the first stage begins in the cycle after `start` is sampled.
- R4: A command byte takes two cycles with `nf_cle` high and the byte on `nf_io_out` with `nf_io_oe` high. `nf_we_n` is low only in the first of those cycles.
- R5: An address length field value n issues n+1 address bytes, least-significant byte first. Each byte takes two cycles with `nf_ale` high and `nf_we_n` low in the first. `nf_cle` and `nf_ale` are never high together.
- R6: A write byte takes three cycles when `wr_valid` is held high: a fetch cycle with `wr_ready` high, a cycle with `nf_we_n` low driving the fetched byte, and a release cycle.
- R7: A read byte takes a cycle with `nf_re_n` low and the bus released, after which the sampled `nf_io_in` byte is held on `rd_data` with `rd_valid` high until `rd_ready`.
- R8: In sector mode the data phase moves the host sector count of sectors. The count drops by one after the last byte of each sector, and the phase ends when it reaches 0. A count of 0 skips the data phase.
- R9: In command mode the sector count is forced to 1 when `start` is accepted, so exactly one sector moves and `sect_left` ends at 0.
- R10: `done` is a one-cycle pulse in the cycle after the last cycle of the last enabled stage, with `busy` low. With nothing to do, `done` comes in the cycle after `start` is sampled.
- R11: While `busy` is high, host register writes and `start` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Readback of the selected register |
| start | input | 1 | Begin a sequence when idle |
| sector_mode | input | 1 | 1 = sector mode, 0 = command mode, sampled at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sect_left | output | 16 | Remaining sector count |
| wr_data | input | 8 | Write byte stream data |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| rd_data | output | 8 | Read byte stream data |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Flash I/O bus out |
| nf_io_oe | output | 1 | Flash I/O bus output enable |
| nf_io_in | input | 8 | Flash I/O bus in |

## Verification
A host register write and a running sequence can meet in the same cycle. The write may come while the sector counter is being decremented or while the address register is feeding the bus. The bench provokes this by writing a new address in the middle of a sector-mode write and also pulsing `start` again. It then judges the result in two ways: the bus byte stream, checked cycle by cycle, must be exactly what the original setup predicts with a single `done`, and the address readback after `done` must still hold the value written before the run.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int CNT_W  = 16;
    localparam int HOST_W = 32;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CMDS = 2'd2;

    typedef struct packed {
        logic [1:0] addr_len;
        logic       data_wr;
        logic       cmd2_en;
        logic       addr_en;
        logic       cmd1_en;
    } cfg_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_C1_LO, ST_C1_HI, ST_AD_LO, ST_AD_HI,
        ST_DT_FETCH, ST_DT_LO, ST_DT_HI, ST_C2_LO, ST_C2_HI
    } state_e;

    typedef enum logic [1:0] {PH_CMD1, PH_ADDR, PH_DATA, PH_CMD2} phase_e;

    function automatic cfg_t cfg_from_bits(input logic [5:0] b);
        cfg_t c;
        c.cmd1_en  = b[0];
        c.addr_en  = b[1];
        c.cmd2_en  = b[2];
        c.data_wr  = b[3];
        c.addr_len = b[5:4];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input cfg_t c);
        return {2'b00, c.addr_len, c.data_wr, c.cmd2_en, c.addr_en, c.cmd1_en};
    endfunction

    // First enabled stage at or after 'from'; later checks win (earlier stage).
    function automatic state_e phase_entry(input phase_e from, input cfg_t c,
                                           input logic data_left);
        state_e s;
        s = ST_IDLE;
        if (c.cmd2_en) s = ST_C2_LO;
        if (from <= PH_DATA && data_left) s = c.data_wr ? ST_DT_FETCH : ST_DT_LO;
        if (from <= PH_ADDR && c.addr_en) s = ST_AD_LO;
        if (from == PH_CMD1 && c.cmd1_en) s = ST_C1_LO;
        return s;
    endfunction

endpackage

// File: rtl/nfc_regs.sv
module nfc_regs
    import nfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_we,
    input  logic [1:0]          host_sel,
    input  logic [HOST_W-1:0]   host_wdata,
    output logic [HOST_W-1:0]   host_rdata,
    input  logic                busy,
    input  logic                go,
    input  logic                sector_mode,
    input  logic                sect_dec,
    output cfg_t                cfg,
    output logic [31:0]         addr,
    output logic [7:0]          cmd1,
    output logic [7:0]          cmd2,
    output logic [CNT_W-1:0]    sect_cnt
);

    cfg_t             cfg_q;
    logic [31:0]      addr_q;
    logic [7:0]       cmd1_q, cmd2_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ok;

    assign wr_ok = host_we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            addr_q <= '0;
            cmd1_q <= '0;
            cmd2_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ok) begin
                case (host_sel)
                    SEL_CTRL: begin
                        cfg_q <= cfg_from_bits(host_wdata[5:0]);
                        cnt_q <= host_wdata[8 +: CNT_W];
                    end
                    SEL_ADDR: addr_q <= host_wdata;
                    SEL_CMDS: begin
                        cmd1_q <= host_wdata[7:0];
                        cmd2_q <= host_wdata[15:8];
                    end
                    default: ;
                endcase
            end
            if (go && !sector_mode) begin
                cnt_q <= CNT_W'(1);
            end else if (sect_dec) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        case (host_sel)
            SEL_CTRL: host_rdata = {{(HOST_W-8-CNT_W){1'b0}}, cnt_q, cfg_to_byte(cfg_q)};
            SEL_ADDR: host_rdata = addr_q;
            SEL_CMDS: host_rdata = {16'h0000, cmd2_q, cmd1_q};
            default:  host_rdata = '0;
        endcase
    end

    assign cfg      = cfg_q;
    assign addr     = addr_q;
    assign cmd1     = cmd1_q;
    assign cmd2     = cmd2_q;
    assign sect_cnt = cnt_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        sect_dec |-> cnt_q != '0); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q)); // R11
    AST_CNT_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !sect_dec) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/nfc_seq_fsm.sv
module nfc_seq_fsm
    import nfc_pkg::*;
#(
    parameter int SECTOR_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sector_mode,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] sect_cnt,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic [7:0]       nf_io_in,
    output logic             go,
    output logic             sect_dec,
    output logic             busy,
    output logic             done,
    output state_e           state,
    output logic [1:0]       addr_idx,
    output logic [7:0]       wbuf
);

    localparam int BYTE_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1;
    localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(SECTOR_BYTES - 1);

    state_e            st_q, nxt;
    logic [1:0]        aidx_q;
    logic [BYTE_W-1:0] bidx_q;
    logic [7:0]        wbuf_q, rbuf_q;
    logic              done_q;
    logic              data_start, data_left, byte_last, xfer;
    state_e            data_entry;

    assign go         = start && (st_q == ST_IDLE);
    assign data_start = sector_mode ? (sect_cnt != '0) : 1'b1;
    assign data_left  = sect_cnt != '0;
    assign byte_last  = bidx_q == BYTE_LAST;
    assign xfer       = (st_q == ST_DT_HI) && (cfg.data_wr || rd_ready);
    assign sect_dec   = xfer && byte_last;
    assign data_entry = cfg.data_wr ? ST_DT_FETCH : ST_DT_LO;

    always_comb begin
        nxt = st_q;
        unique case (st_q)
            ST_IDLE:     if (go) nxt = phase_entry(PH_CMD1, cfg, data_start);
            ST_C1_LO:    nxt = ST_C1_HI;
            ST_C1_HI:    nxt = phase_entry(PH_ADDR, cfg, data_left);
            ST_AD_LO:    nxt = ST_AD_HI;
            ST_AD_HI:    nxt = (aidx_q == cfg.addr_len) ?
                               phase_entry(PH_DATA, cfg, data_left) : ST_AD_LO;
            ST_DT_FETCH: if (wr_valid) nxt = ST_DT_LO;
            ST_DT_LO:    nxt = ST_DT_HI;
            ST_DT_HI: begin
                if (xfer) begin
                    if (!byte_last || sect_cnt > CNT_W'(1)) nxt = data_entry;
                    else nxt = phase_entry(PH_CMD2, cfg, 1'b0);
                end
            end
            ST_C2_LO:    nxt = ST_C2_HI;
            ST_C2_HI:    nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            aidx_q <= '0;
            bidx_q <= '0;
            wbuf_q <= '0;
            rbuf_q <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= nxt;
            done_q <= ((st_q != ST_IDLE) || go) && (nxt == ST_IDLE);
            if (st_q == ST_AD_HI) begin
                aidx_q <= (aidx_q == cfg.addr_len) ? 2'd0 : aidx_q + 2'd1;
            end
            if (xfer) begin
                bidx_q <= byte_last ? '0 : bidx_q + BYTE_W'(1);
            end
            if (st_q == ST_DT_FETCH && wr_valid) begin
                wbuf_q <= wr_data;
            end
            if (st_q == ST_DT_LO && !cfg.data_wr) begin
                rbuf_q <= nf_io_in;
            end
        end
    end

    assign wr_ready = st_q == ST_DT_FETCH;
    assign rd_valid = (st_q == ST_DT_HI) && !cfg.data_wr;
    assign rd_data  = rbuf_q;
    assign busy     = st_q != ST_IDLE;
    assign done     = done_q;
    assign state    = st_q;
    assign addr_idx = aidx_q;
    assign wbuf     = wbuf_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
    AST_ADDR_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AD_HI) |-> (aidx_q <= cfg.addr_len)); // R5
    AST_FETCH_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> cfg.data_wr); // R6

endmodule

// File: rtl/nfc_pin_drv.sv
module nfc_pin_drv
    import nfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  state_e      state,
    input  logic        data_wr,
    input  logic [31:0] addr,
    input  logic [1:0]  addr_idx,
    input  logic [7:0]  cmd1,
    input  logic [7:0]  cmd2,
    input  logic [7:0]  wbuf,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_io_out,
    output logic        nf_io_oe
);

    logic in_data;

    assign in_data  = (state == ST_DT_LO) || (state == ST_DT_HI);
    assign nf_cle   = (state == ST_C1_LO) || (state == ST_C1_HI) ||
                      (state == ST_C2_LO) || (state == ST_C2_HI);
    assign nf_ale   = (state == ST_AD_LO) || (state == ST_AD_HI);
    assign nf_we_n  = !((state == ST_C1_LO) || (state == ST_C2_LO) ||
                        (state == ST_AD_LO) || (state == ST_DT_LO && data_wr));
    assign nf_re_n  = !(state == ST_DT_LO && !data_wr);
    assign nf_io_oe = nf_cle || nf_ale || (in_data && data_wr);

    always_comb begin
        case (state)
            ST_C1_LO, ST_C1_HI: nf_io_out = cmd1;
            ST_C2_LO, ST_C2_HI: nf_io_out = cmd2;
            ST_AD_LO, ST_AD_HI: nf_io_out = addr[{addr_idx, 3'b000} +: 8];
            ST_DT_LO, ST_DT_HI: nf_io_out = data_wr ? wbuf : 8'h00;
            default:            nf_io_out = 8'h00;
        endcase
    end

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(nf_cle && nf_ale)); // R5
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !nf_we_n |=> nf_we_n); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n)); // R7
    AST_BUS_FREE_READ: assert property (@(posedge clk) disable iff (rst)
        !nf_re_n |-> !nf_io_oe); // R7

endmodule

// File: rtl/nfc_sequencer.sv
module nfc_sequencer
    import nfc_pkg::*;
#(
    parameter int SECTOR_BYTES = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_we,
    input  logic [1:0]   host_sel,
    input  logic [31:0]  host_wdata,
    output logic [31:0]  host_rdata,
    input  logic         start,
    input  logic         sector_mode,
    output logic         busy,
    output logic         done,
    output logic [15:0]  sect_left,
    input  logic [7:0]   wr_data,
    input  logic         wr_valid,
    output logic         wr_ready,
    output logic [7:0]   rd_data,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic         nf_cle,
    output logic         nf_ale,
    output logic         nf_we_n,
    output logic         nf_re_n,
    output logic [7:0]   nf_io_out,
    output logic         nf_io_oe,
    input  logic [7:0]   nf_io_in
);

    cfg_t             cfg;
    logic [31:0]      addr;
    logic [7:0]       cmd1, cmd2, wbuf;
    logic [CNT_W-1:0] sect_cnt;
    logic             go, sect_dec, busy_i;
    state_e           state;
    logic [1:0]       addr_idx;

    nfc_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .busy        (busy_i),
        .go          (go),
        .sector_mode (sector_mode),
        .sect_dec    (sect_dec),
        .cfg         (cfg),
        .addr        (addr),
        .cmd1        (cmd1),
        .cmd2        (cmd2),
        .sect_cnt    (sect_cnt)
    );

    nfc_seq_fsm #(.SECTOR_BYTES(SECTOR_BYTES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sector_mode (sector_mode),
        .cfg         (cfg),
        .sect_cnt    (sect_cnt),
        .wr_data     (wr_data),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .nf_io_in    (nf_io_in),
        .go          (go),
        .sect_dec    (sect_dec),
        .busy        (busy_i),
        .done        (done),
        .state       (state),
        .addr_idx    (addr_idx),
        .wbuf        (wbuf)
    );

    nfc_pin_drv u_pins (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .data_wr   (cfg.data_wr),
        .addr      (addr),
        .addr_idx  (addr_idx),
        .cmd1      (cmd1),
        .cmd2      (cmd2),
        .wbuf      (wbuf),
        .nf_cle    (nf_cle),
        .nf_ale    (nf_ale),
        .nf_we_n   (nf_we_n),
        .nf_re_n   (nf_re_n),
        .nf_io_out (nf_io_out),
        .nf_io_oe  (nf_io_oe)
    );

    assign busy      = busy_i;
    assign sect_left = sect_cnt;

endmodule

// File: tb/nfc_sequencer_tb.sv
module nfc_sequencer_tb;

    localparam int SB = 4;
    localparam int EV_CMD = 1, EV_ADR = 2, EV_WR = 3, EV_RD = 4, EV_DONE = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        start = 1'b0;
    logic        sector_mode = 1'b0;
    logic        busy, done;
    logic [15:0] sect_left;
    logic [7:0]  wr_data = 8'h90;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out;
    logic [7:0]  nf_io_in = 8'h00;

    always #4 clk = ~clk;

    nfc_sequencer #(.SECTOR_BYTES(SB)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start),
        .sector_mode(sector_mode), .busy(busy), .done(done), .sect_left(sect_left),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    kind;
        int    data;
        int    cyc;
        string req;
    } ev_t;

    ev_t exp_q[$];
    int  n_checks = 0;
    int  n_errs   = 0;
    int  exp_wi   = 0;
    int  exp_ri   = 0;
    bit  finished = 1'b0;

    function automatic void note(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endfunction

    function automatic void push(int kind, int data, int c, string req);
        ev_t e;
        e.kind = kind; e.data = data; e.cyc = c; e.req = req;
        exp_q.push_back(e);
    endfunction

    // Scoreboard monitor side
    function automatic void take(int kind, int data);
        ev_t e;
        if (exp_q.size() == 0) begin
            note(1'b0, "R3", "unexpected event kind", kind, 0);
            return;
        end
        e = exp_q.pop_front();
        n_checks++;
        if (e.kind != kind || e.data != data || e.cyc != cyc) begin
            n_errs++;
            $display("FAIL %s: event actual kind %0d data %02h cycle %0d, expected kind %0d data %02h cycle %0d",
                     e.req, kind, data, cyc, e.kind, e.data, e.cyc);
        end
    endfunction

    int mon_kind;
    always @(negedge clk) begin
        if (!rst) begin
            if (!nf_we_n) begin
                mon_kind = nf_cle ? EV_CMD : (nf_ale ? EV_ADR : EV_WR);
                take(mon_kind, int'(nf_io_out));
                if (!nf_io_oe) note(1'b0, "R4", "io_oe during write strobe", 0, 1);
            end
            if (rd_valid && rd_ready) take(EV_RD, int'(rd_data));
            if (done) take(EV_DONE, 0);
        end
    end

    // Byte-stream and flash models
    int wr_idx = 0, rd_idx = 0;
    bit take_pend = 1'b0;
    always @(negedge clk) begin
        if (take_pend) begin
            wr_idx++;
            take_pend = 1'b0;
        end
        if (wr_ready) take_pend = 1'b1;
        wr_data = 8'h90 + 8'(wr_idx);
        if (!nf_re_n) begin
            nf_io_in = 8'h3C + 8'(rd_idx);
            rd_idx++;
        end
    end

    task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        host_sel = sel;
        #1 d = host_rdata;
    endtask

    // Scoreboard driver side
    task automatic launch(input logic [7:0] ctrl, input logic [15:0] cnt,
                          input logic [31:0] addr, input logic [7:0] c1,
                          input logic [7:0] c2, input bit smode);
        int t0, off, nsec;
        host_write(2'd0, {8'h00, cnt, ctrl});
        host_write(2'd1, addr);
        host_write(2'd2, {16'h0000, c2, c1});
        @(negedge clk);
        start = 1'b1; sector_mode = smode;
        @(posedge clk);
        #1 t0 = cyc;
        off = 0;
        if (ctrl[0]) begin push(EV_CMD, int'(c1), t0 + off, "R4/R3"); off += 2; end
        if (ctrl[1]) begin
            for (int i = 0; i <= int'(ctrl[5:4]); i++) begin
                push(EV_ADR, int'(addr[8*i +: 8]), t0 + off, "R5/R3");
                off += 2;
            end
        end
        nsec = smode ? int'(cnt) : 1;
        for (int s = 0; s < nsec; s++) begin
            for (int b = 0; b < SB; b++) begin
                if (ctrl[3]) begin
                    push(EV_WR, int'(8'h90 + 8'(exp_wi)), t0 + off + 1, "R6/R8");
                    exp_wi++; off += 3;
                end else begin
                    push(EV_RD, int'(8'h3C + 8'(exp_ri)), t0 + off + 1, "R7/R8");
                    exp_ri++; off += 2;
                end
            end
        end
        if (ctrl[2]) begin push(EV_CMD, int'(c2), t0 + off, "R4/R3"); off += 2; end
        push(EV_DONE, 0, t0 + off, "R10");
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        note(exp_q.size() == 0, "R3", "missing expected events", exp_q.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        note(1'b0, "R10", "watchdog expired", 0, 1);
        finish_up();
    end

    logic [31:0] rb;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        note(busy == 1'b0, "R1", "busy", busy, 0);
        note(done == 1'b0, "R1", "done", done, 0);
        note({nf_cle, nf_ale, nf_io_oe} == 3'b000, "R1", "cle/ale/oe", {nf_cle, nf_ale, nf_io_oe}, 0);
        note({nf_we_n, nf_re_n} == 2'b11, "R1", "we_n/re_n", {nf_we_n, nf_re_n}, 3);
        note(sect_left == 16'd0, "R1", "sect_left", sect_left, 0);
        host_read(2'd0, rb);
        note(rb == 32'h0, "R1", "control readback", rb, 0);

        // R2 register layout and reserved bits
        host_write(2'd0, 32'hFFFF_FFFF);
        host_read(2'd0, rb);
        note(rb == 32'h00FF_FF3F, "R2", "control reserved bits", rb, 32'h00FF_FF3F);
        host_write(2'd1, 32'hCAFE_0123);
        host_read(2'd1, rb);
        note(rb == 32'hCAFE_0123, "R2", "address readback", rb, 32'hCAFE_0123);
        host_write(2'd2, 32'hFFFF_A55A);
        host_read(2'd2, rb);
        note(rb == 32'h0000_A55A, "R2", "commands readback", rb, 32'h0000_A55A);
        host_read(2'd3, rb);
        note(rb == 32'h0, "R2", "unused select", rb, 0);

        // R9 command mode write, all stages, 4 address bytes; count field 7 forced to 1
        launch(8'h3F, 16'd7, 32'h4433_2211, 8'h80, 8'h10, 1'b0);
        note(sect_left == 16'd1, "R9", "count forced to one", sect_left, 1);
        drain();
        note(sect_left == 16'd0, "R9", "count after run", sect_left, 0);

        // R7 command mode read, address only, 2 bytes
        launch(8'h12, 16'd0, 32'h0000_BEEF, 8'h00, 8'h00, 1'b0);
        drain();

        // R8 sector mode read, 3 sectors, both commands, 1 address byte
        launch(8'h07, 16'd3, 32'h0000_005A, 8'h00, 8'h30, 1'b1);
        drain();
        note(sect_left == 16'd0, "R8", "count after sectors", sect_left, 0);

        // R8 sector mode with zero count skips data
        launch(8'h09, 16'd0, 32'h0, 8'h70, 8'h00, 1'b1);
        drain();

        // R10 nothing to do: done in the cycle after start
        launch(8'h00, 16'd0, 32'h0, 8'h00, 8'h00, 1'b1);
        drain();

        // R11 writes and start ignored while busy
        launch(8'h1A, 16'd2, 32'h0000_BEEF, 8'h00, 8'h00, 1'b1);
        repeat (2) @(negedge clk);
        note(busy == 1'b1, "R11", "busy mid-run", busy, 1);
        host_write(2'd1, 32'h1234_5678);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        host_read(2'd1, rb);
        note(rb == 32'h0000_BEEF, "R11", "address kept", rb, 32'h0000_BEEF);
        note(sect_left == 16'd0, "R8", "count after write sectors", sect_left, 0);

        finish_up();
    end

endmodule